// File: doc/BRIEF.md
# Interlaced Frame Reset Generator

This block produces a single-clock frame reset pulse once per interlaced frame. Its inputs are a horizontal and a vertical sync, both already in the pixel-clock domain. Each sync has its own inversion control. Both syncs are re-registered and edge-detected. A pixel counter restarts on every line sync. From that counter the block builds a half-line window, a signal that is high for half of a nominal line. A vertical sync edge that arrives while the window is high becomes the frame reset.

On nominal interlaced timing, one field has its vertical sync in the first half of the line and the other field has it in the second half. So only one field per frame produces a reset. Line lengths can drift from nominal, and vertical sync can sit close to a window edge. For these cases a 4-bit align value moves the whole window later in steps of 12 clocks. This keeps the vertical sync of exactly one field inside the window.

Top module: `frame_reset_gen`

## Requirements
- R1: When `hsync_inv` is 1, `hsync_in` is inverted before any other processing, and when it is 0 the signal passes unchanged. `vsync_inv` and `vsync_in` behave the same way. All behaviour below refers to the sync signals after this stage.
- R2: Each sync passes through two synchronizing flops followed by a rising-edge detector. A sync rise that is first sampled on clock edge k is seen as a one-clock event after edge k+1.
- R3: A horizontal sync rise first sampled on edge h clears the 11-bit pixel counter to 0 on edge h+2. The counter then increments once per clock.
- R4: `half_line` rises on the edge after the counter equals 12·N, where N is the unsigned 4-bit value on `align`. With a horizontal sync rise sampled on edge h, `half_line` is high after edges h+3+12·N through h+2+384+12·N.
- R5: `half_line` falls on the edge after the counter equals 384+12·N, which is half of the nominal 768-clock line plus the offset.
- R6: Every `align` value from 0 to 15 shifts both window edges by the same 12·N clocks. The window is always 384 clocks wide.
- R7: `frame_rst` is high for the one clock after edge v+2 exactly when a vertical sync rise is first sampled on edge v and `half_line` was high after edge v+1. Otherwise `frame_rst` is low.
- R8: When no horizontal sync arrives, the pixel counter stops at its maximum value of 2047 and does not wrap. No new window opens until the next horizontal sync.
- R9: A synchronous active-high `rst` clears `half_line` and `frame_rst` to 0. After reset, no window opens until a horizontal sync has been seen.
- R10: `frame_rst` never stays high for more than one clock per vertical sync edge.
- R11: On nominal 768-clock lines with N=0, take one field whose vertical sync is in the first half of the line and one field whose vertical sync is in the second half. Together these two fields produce exactly one frame reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, raw polarity |
| vsync_in | input | 1 | Vertical sync, raw polarity |
| hsync_inv | input | 1 | 1 inverts the horizontal sync |
| vsync_inv | input | 1 | 1 inverts the vertical sync |
| align | input | 4 | Window offset N, in units of 12 clocks |
| half_line | output | 1 | Half-line window |
| frame_rst | output | 1 | One-clock frame reset pulse |

## Verification
Two situations are hard to reach from the ports.

The first is a vertical sync edge placed exactly on a window boundary. The bench reaches it with directed lines whose vertical sync offsets sit one clock either side of each window edge for a non-zero align value.

The second is the counter saturating. It only matters after more than 2048 clocks without a line sync. The bench creates it with a single line sync followed by a long idle gap, then places a vertical sync where a wrapping counter would have reopened the window.

Random segments with random polarity, align and line length cover everything in between. The bench's cycle model predicts both outputs on every clock.

// File: rtl/frame_reset_gen.sv
module frame_reset_gen #(
  parameter int PIX_PER_LINE = 768,
  parameter int ALIGN_STEP   = 12,
  parameter int CNT_W        = 11,
  parameter int ALIGN_W      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic               hsync_inv,
  input  logic               vsync_inv,
  input  logic [ALIGN_W-1:0] align,
  output logic               half_line,
  output logic               frame_rst
);
  localparam logic [CNT_W-1:0] HALF    = CNT_W'(PIX_PER_LINE / 2);
  localparam logic [CNT_W-1:0] STEP    = CNT_W'(ALIGN_STEP);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       hs_pipe, vs_pipe;
  logic             hs_edge, vs_edge;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] win_start, win_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_pipe <= '0;
      vs_pipe <= '0;
    end else begin
      hs_pipe <= {hs_pipe[1:0], hsync_in ^ hsync_inv};
      vs_pipe <= {vs_pipe[1:0], vsync_in ^ vsync_inv};
    end
  end

  assign hs_edge = hs_pipe[1] & ~hs_pipe[2];
  assign vs_edge = vs_pipe[1] & ~vs_pipe[2];

  always_ff @(posedge clk) begin
    if (rst)                cnt <= CNT_MAX;
    else if (hs_edge)       cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign win_start = CNT_W'(align) * STEP;
  assign win_stop  = win_start + HALF;

  always_ff @(posedge clk) begin
    if (rst)                   half_line <= 1'b0;
    else if (cnt == win_stop)  half_line <= 1'b0;
    else if (cnt == win_start) half_line <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) frame_rst <= 1'b0;
    else     frame_rst <= vs_edge & half_line;
  end
endmodule

module frame_reset_gen_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             hs_edge,
  input logic             vs_edge,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] win_start,
  input logic             half_line,
  input logic             frame_rst
);
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    hs_edge |=> cnt == '0); // R3
  AST_WIN_OPEN: assert property (@(posedge clk) disable iff (rst)
    $rose(half_line) |-> $past(cnt) == $past(win_start)); // R4
  AST_FR_GATED: assert property (@(posedge clk) disable iff (rst)
    frame_rst |-> $past(half_line) && $past(vs_edge)); // R7
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (cnt == '1 && !hs_edge) |=> cnt == '1); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!half_line && !frame_rst)); // R9
  AST_FR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_rst |=> !frame_rst); // R10
endmodule

bind frame_reset_gen frame_reset_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .hs_edge(hs_edge), .vs_edge(vs_edge), .cnt(cnt),
  .win_start(win_start), .half_line(half_line), .frame_rst(frame_rst)
);

// File: tb/frame_reset_gen_tb.sv
module frame_reset_gen_tb;
  localparam int SENT = -1000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_in = 1'b0, vsync_in = 1'b0, hsync_inv = 1'b0, vsync_inv = 1'b0;
  logic [3:0] align = '0;
  logic half_line, frame_rst;

  int tests = 0, fails = 0;
  int t = 0, h_cur = SENT, h_prev = SENT, vr = SENT, skip = 0;
  logic hl_prev = 1'b0, vl_prev = 1'b0, fr_prev = 1'b0;
  int fr_count = 0;
  string phase = "R8 reset";
  bit done = 0;

  always #4 clk = ~clk;

  frame_reset_gen u_dut (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hsync_inv(hsync_inv), .vsync_inv(vsync_inv), .align(align),
    .half_line(half_line), .frame_rst(frame_rst)
  );

  function automatic bit exp_win(input int x);
    int h, d;
    h = (x - 4 >= h_cur) ? h_cur : h_prev;
    d = x - h - 4;
    return (d >= 12 * int'(align)) && (d < 384 + 12 * int'(align));
  endfunction

  function automatic bit exp_fr(input int x);
    return (vr == x - 3) && exp_win(x - 1);
  endfunction

  task automatic check_outputs();
    bit ew, ef;
    if (skip > 0) begin
      skip--;
      fr_prev = 1'b0;
      return;
    end
    ew = exp_win(t);
    ef = exp_fr(t);
    tests += 2;
    if (half_line !== ew) begin
      fails++;
      $display("FAIL %s R4/R5 half_line step %0d: got %b exp %b", phase, t, half_line, ew);
    end
    if (frame_rst !== ef) begin
      fails++;
      $display("FAIL %s R7 frame_rst step %0d: got %b exp %b", phase, t, frame_rst, ef);
    end
    if (frame_rst && fr_prev) begin
      tests++; fails++;
      $display("FAIL %s R10 frame_rst held: got 1 exp 0", phase);
    end
    if (frame_rst === 1'b1) fr_count++;
    fr_prev = frame_rst;
  endtask

  task automatic step(input logic hl, input logic vl);
    @(negedge clk);
    check_outputs();
    if (hl && !hl_prev) begin h_prev = h_cur; h_cur = t; end
    if (vl && !vl_prev) vr = t;
    hl_prev = hl; vl_prev = vl;
    hsync_in = hl ^ hsync_inv;
    vsync_in = vl ^ vsync_inv;
    t++;
  endtask

  task automatic do_reset(input logic hinv, input logic vinv, input logic [3:0] n);
    @(negedge clk);
    rst = 1'b1;
    hsync_inv = hinv; vsync_inv = vinv; align = n;
    hsync_in = hinv; vsync_in = vinv;
    skip = 5;
    repeat (4) step(1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    h_cur = SENT; h_prev = SENT; vr = SENT;
    hl_prev = 1'b0; vl_prev = 1'b0;
    phase = "R9 reset";
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic run_line(input int len, input int vs_off);
    for (int i = 0; i < len; i++)
      step(i < 40, (vs_off >= 0) && (i >= vs_off) && (i < vs_off + 100));
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset(1'b0, 1'b0, 4'd0);

    phase = "R11 interlace";
    fr_count = 0;
    run_line(768, 100);
    run_line(768, 484);
    run_line(768, -1);
    tests++;
    if (fr_count != 1) begin
      fails++;
      $display("FAIL R11 resets per frame: got %0d exp 1", fr_count);
    end

    do_reset(1'b0, 1'b0, 4'd3);
    phase = "R6 boundary";
    fr_count = 0;
    run_line(768, 38);
    run_line(768, 37);
    run_line(768, 421);
    run_line(768, 422);
    run_line(768, -1);
    tests++;
    if (fr_count != 2) begin
      fails++;
      $display("FAIL R6 boundary resets: got %0d exp 2", fr_count);
    end

    do_reset(1'b1, 1'b1, 4'd15);
    phase = "R1 inverted";
    run_line(768, 200);
    run_line(800, 650);
    run_line(768, -1);

    do_reset(1'b0, 1'b0, 4'd0);
    phase = "R8 saturation";
    fr_count = 0;
    for (int i = 0; i < 2400; i++)
      step(i < 40, (i >= 2150) && (i < 2250));
    tests++;
    if (fr_count != 0) begin
      fails++;
      $display("FAIL R8 reset after missing line sync: got %0d exp 0", fr_count);
    end

    phase = "R2 R3 random";
    for (int seg = 0; seg < 8; seg++) begin
      do_reset(1'($urandom % 2), 1'($urandom % 2), 4'($urandom % 16));
      phase = "R2 R3 random";
      for (int ln = 0; ln < 5; ln++) begin
        int len, off;
        len = 600 + int'($urandom % 300);
        off = ($urandom % 3 == 0) ? -1 : int'($urandom % len);
        run_line(len, off);
      end
      run_line(700, -1);
    end

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end
endmodule